// File: doc/BRIEF.md
# Daisy-Chained Delay and Attenuation Control Slave

This block is the serial control slave that sits beside each delay-and-attenuation RF module in a chain. A single controller drives one data line into the first module. Every module shifts the bits it receives into its own frame register, and it passes the bit leaving the far end of that register to the next module. One long serial burst therefore reaches every module. The controller sends the frame for the farthest module first and the frame for the nearest module last.

Nothing reaches the outputs while bits are moving. A separate latch strobe, shared by all modules, copies the held frame into the output latch, so every element changes state on the same clock. Each frame carries a checksum. A module accepts the strobe only if its frame is intact and the shift count is a whole number of frames. When the strobe is refused, the module keeps its previous outputs and raises a sticky error.

The frame carries the delay as a step count of 4 ps. The slave converts that count into the weighted bit code of the delay line. Seven of its bits are binary weighted from 4 ps to 256 ps, and an eighth bit adds a second 256 ps.

Top module: `chainCtlSlave`

## Requirements
- R1: While reset is asserted and after it is released, the delay code, the attenuation code, the error flag and the serial output are all zero.
- R2: Each clock with shiftEn high (and no strobe) shifts serIn into a 22-bit register. serOut shows the oldest bit of that register, updated on the falling clock edge. A bit that enters a module therefore enters the next module on the 23rd shift after it entered, and reaches serOut right after the 22nd.
- R3: The frame is sent MSB first as 22 bits: the delay step count (8 bits), then the attenuation code (6 bits), then an 8-bit checksum. A module acts on the last 22 bits it has shifted in.
- R4: The checksum is a CRC computed over the 14 payload bits, MSB first, with polynomial x^8+x^2+x+1 and initial value 0x00.
- R5: The outputs load only when the strobe arrives, the checksum matches, and a non-zero whole multiple of 22 bits has been shifted since the previous strobe or reset. In every other case the outputs hold their values.
- R6: A strobe that does not load sets errFlag. Only reset clears errFlag, and a successful load leaves it unchanged.
- R7: The strobe takes priority over shifting. If shiftEn is high in the same cycle, that cycle shifts nothing, and the frame bit count starts again from zero.
- R8: For step counts 0 to 127, delayCode[6:0] equals the count and delayCode[7] is 0.
- R9: For step counts 128 to 191, delayCode[7] is 1 and delayCode[6:0] equals the count minus 64.
- R10: For step counts above 191, delayCode is 0xFF (764 ps).
- R11: attenCode equals the 6-bit attenuation field of the accepted frame, at 0.5 dB per LSB.
- R12: New outputs appear on the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serIn | input | 1 | Serial data from the previous module or from the controller |
| shiftEn | input | 1 | Shift the serIn bit in this cycle |
| latchStrobe | input | 1 | Shared strobe that requests the output update |
| serOut | output | 1 | Serial data to the next module, updated on the falling edge |
| delayCode | output | 8 | Weighted delay bits; bit 7 is the second 256 ps bit |
| attenCode | output | 6 | Attenuator code, 0.5 dB per LSB |
| errFlag | output | 1 | Sticky flag for a refused strobe |

## Verification
The hardest cases to reach are the ones where the checksum is correct but the frame count is wrong, and the one where a strobe lands in the same cycle as a shift. From the ports, both look just like a good update. To reach them, the bench adds one stray bit ahead of an otherwise valid burst, raises shiftEn in the strobe cycle, and then shows that the next aligned frame loads. The bench chains two slaves, so it also checks that the far frame crosses the first module intact. It corrupts the checksum of one module at a time, so it can check that only that module refuses the strobe.

// File: rtl/chainCtlPkg.sv
package chainCtlPkg;
  localparam int DLY_W   = 8;
  localparam int ATT_W   = 6;
  localparam int CRC_W   = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;
  localparam int PAY_W   = DLY_W + ATT_W;
  localparam int FRAME_W = PAY_W + CRC_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  // delay code: low bits binary, top bit duplicates the heaviest low bit
  localparam int LOW_W   = DLY_W - 1;
  localparam int LOW_MAX = (1 << LOW_W) - 1;
  localparam int HEAVY   = 1 << (LOW_W - 1);
  localparam int TOP_MAX = LOW_MAX + HEAVY;

  typedef struct packed {
    logic shift;
    logic load;
  } ctlStrobes_t;

  function automatic logic [CRC_W-1:0] crcCalc(input logic [PAY_W-1:0] pay);
    logic [CRC_W-1:0] acc;
    logic fb;
    acc = '0;
    for (int i = PAY_W - 1; i >= 0; i--) begin
      fb  = acc[CRC_W-1] ^ pay[i];
      acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return acc;
  endfunction

  function automatic logic [DLY_W-1:0] dlyEncode(input logic [DLY_W-1:0] steps);
    if (steps > DLY_W'(TOP_MAX))
      return '1;
    else if (steps > DLY_W'(LOW_MAX))
      return {1'b1, LOW_W'(steps - DLY_W'(HEAVY))};
    else
      return {1'b0, steps[LOW_W-1:0]};
  endfunction
endpackage

// File: rtl/chainCtlDatapath.sv
module chainCtlDatapath
  import chainCtlPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  ctlStrobes_t       strb,
  output logic              crcOk,
  output logic              serOut,
  output logic [DLY_W-1:0]  delayCode,
  output logic [ATT_W-1:0]  attenCode
);
  logic [FRAME_W-1:0] shiftReg;
  logic [PAY_W-1:0]   payload;
  logic [CRC_W-1:0]   rxCrc;

  assign payload = shiftReg[FRAME_W-1:CRC_W];
  assign rxCrc   = shiftReg[CRC_W-1:0];
  assign crcOk   = (crcCalc(payload) == rxCrc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strb.shift) shiftReg <= {shiftReg[FRAME_W-2:0], serIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayCode <= '0;
      attenCode <= '0;
    end else if (strb.load) begin
      delayCode <= dlyEncode(payload[PAY_W-1:ATT_W]);
      attenCode <= payload[ATT_W-1:0];
    end
  end

  // falling-edge launch gives the next module a half cycle of hold
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) serOut <= 1'b0;
    else serOut <= shiftReg[FRAME_W-1];
  end

  AST_LOAD_NEEDS_CRC: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> crcOk); // R5
  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ($stable(delayCode) && $stable(attenCode))); // R5
  AST_SECOND_HEAVY_BIT: assert property (@(posedge clk) disable iff (!rstN)
    delayCode[DLY_W-1] |-> delayCode[DLY_W-2]); // R9
endmodule

// File: rtl/chainCtlControl.sv
module chainCtlControl
  import chainCtlPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        shiftEn,
  input  logic        latchStrobe,
  input  logic        crcOk,
  output ctlStrobes_t strb,
  output logic        errFlag
);
  logic [CNT_W-1:0] bitCnt;
  logic             haveFrame;
  logic             frameAligned;

  assign frameAligned = (bitCnt == '0) && haveFrame;
  assign strb.shift   = shiftEn && !latchStrobe;
  assign strb.load    = latchStrobe && crcOk && frameAligned;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      haveFrame <= 1'b0;
      errFlag   <= 1'b0;
    end else if (latchStrobe) begin
      bitCnt    <= '0;
      haveFrame <= 1'b0;
      if (!(crcOk && frameAligned)) errFlag <= 1'b1;
    end else if (shiftEn) begin
      if (bitCnt == CNT_W'(FRAME_W - 1)) begin
        bitCnt    <= '0;
        haveFrame <= 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt < CNT_W'(FRAME_W)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R6
  AST_REFUSED_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (latchStrobe && !strb.load) |=> errFlag); // R6
  AST_STROBE_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    latchStrobe |=> (bitCnt == '0 && !haveFrame)); // R7
endmodule

// File: rtl/chainCtlSlave.sv
module chainCtlSlave
  import chainCtlPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             serIn,
  input  logic             shiftEn,
  input  logic             latchStrobe,
  output logic             serOut,
  output logic [DLY_W-1:0] delayCode,
  output logic [ATT_W-1:0] attenCode,
  output logic             errFlag
);
  ctlStrobes_t strb;
  logic        crcOk;

  chainCtlControl i_control (
    .clk(clk), .rstN(rstN), .shiftEn(shiftEn), .latchStrobe(latchStrobe),
    .crcOk(crcOk), .strb(strb), .errFlag(errFlag)
  );

  chainCtlDatapath i_datapath (
    .clk(clk), .rstN(rstN), .serIn(serIn), .strb(strb), .crcOk(crcOk),
    .serOut(serOut), .delayCode(delayCode), .attenCode(attenCode)
  );
endmodule

// File: tb/test_chainCtlSlave.sv
module test_chainCtlSlave;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serIn = 1'b0, shiftEn = 1'b0, latchStrobe = 1'b0;
  logic serOutNear, serOutFar;
  logic [7:0] dlyNear, dlyFar;
  logic [5:0] attNear, attFar;
  logic errNear, errFar;
  int checks = 0, errors = 0;
  logic [7:0] expDlyNear = 0, expDlyFar = 0;
  logic [5:0] expAttNear = 0, expAttFar = 0;
  logic expErrNear = 0, expErrFar = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chainCtlSlave i_chainCtlSlave (
    .clk(clk), .rstN(rstN), .serIn(serIn), .shiftEn(shiftEn), .latchStrobe(latchStrobe),
    .serOut(serOutNear), .delayCode(dlyNear), .attenCode(attNear), .errFlag(errNear));
  chainCtlSlave i_chainCtlSlaveFar (
    .clk(clk), .rstN(rstN), .serIn(serOutNear), .shiftEn(shiftEn), .latchStrobe(latchStrobe),
    .serOut(serOutFar), .delayCode(dlyFar), .attenCode(attFar), .errFlag(errFar));

  function automatic logic [7:0] refCrc(input logic [13:0] p);
    logic [21:0] r = {p, 8'h00};
    for (int i = 21; i >= 8; i--) if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
    return r[7:0];
  endfunction

  function automatic logic [7:0] refCode(input logic [7:0] s);
    if (s >= 8'd192) return 8'hFF;
    if (s >= 8'd128) return 8'h80 + (s - 8'd64);
    return s;
  endfunction

  function automatic logic [21:0] mkFrame(input logic [7:0] s, input logic [5:0] a, input logic bad);
    return {s, a, refCrc({s, a}) ^ (bad ? 8'h10 : 8'h00)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic driveBit(input logic b);
    serIn = b; shiftEn = 1'b1;
    @(negedge clk); #1;
    shiftEn = 1'b0;
  endtask

  task automatic sendChain(input logic [43:0] bits);
    for (int i = 43; i >= 0; i--) driveBit(bits[i]);
  endtask

  task automatic pulseStrobe(input logic withShift);
    latchStrobe = 1'b1; shiftEn = withShift; serIn = 1'b1;
    @(negedge clk); #1;
    latchStrobe = 1'b0; shiftEn = 1'b0;
  endtask

  task automatic checkAll(input string req);
    chk({req, " near delay"}, 32'(dlyNear), 32'(expDlyNear));
    chk({req, " near atten"}, 32'(attNear), 32'(expAttNear));
    chk({req, " far delay"}, 32'(dlyFar), 32'(expDlyFar));
    chk({req, " far atten"}, 32'(attFar), 32'(expAttFar));
    chk({req, " near err"}, 32'(errNear), 32'(expErrNear));
    chk({req, " far err"}, 32'(errFar), 32'(expErrFar));
  endtask

  // one chained update; misalign adds a stray leading bit
  task automatic update(input logic [7:0] sN, input logic [5:0] aN, input logic badN,
                        input logic [7:0] sF, input logic [5:0] aF, input logic badF,
                        input logic misalign, input string req);
    if (misalign) driveBit(1'b1);
    sendChain({mkFrame(sF, aF, badF), mkFrame(sN, aN, badN)});
    checkAll({req, " before strobe R12"});
    pulseStrobe(1'b0);
    if (misalign || badN) expErrNear = 1'b1;
    else begin expDlyNear = refCode(sN); expAttNear = aN; end
    if (misalign || badF) expErrFar = 1'b1;
    else begin expDlyFar = refCode(sF); expAttFar = aF; end
    checkAll(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [43:0] pat;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    checkAll("R1 in reset");
    chk("R1 serOut", 32'(serOutNear), 0);
    rstN = 1'b1;
    @(negedge clk); #1;
    checkAll("R1 after reset");

    // R2: the first bit of the burst reaches serOut after 22 shifts
    pat = {mkFrame(8'd200, 6'd9, 1'b0), mkFrame(8'd37, 6'd63, 1'b0)};
    for (int i = 43; i >= 0; i--) begin
      driveBit(pat[i]);
      if (i == 22) chk("R2 near serOut after 22 shifts", 32'(serOutNear), 32'(pat[43]));
      if (i == 21) chk("R2 near serOut after 23 shifts", 32'(serOutNear), 32'(pat[42]));
    end
    pulseStrobe(1'b0);
    expDlyNear = 8'd37; expAttNear = 6'd63;   // R8 R11
    expDlyFar = 8'hFF; expAttFar = 6'd9;      // R10, frame crossed the chain R3
    checkAll("R3 R4 chained load");

    update(8'd0, 6'd0, 0, 8'd127, 6'd1, 0, 0, "R8 edges");
    chk("R8 127 code", 32'(dlyFar), 32'h7F);
    update(8'd128, 6'd32, 0, 8'd191, 6'd31, 0, 0, "R9 edges");
    chk("R9 128 code", 32'(dlyNear), 32'hC0);
    chk("R9 191 code", 32'(dlyFar), 32'hFF);
    update(8'd192, 6'd5, 0, 8'd255, 6'd6, 0, 0, "R10 clamp");
    chk("R6 good strobes leave err clear", 32'(errNear | errFar), 0);

    // R7: strobe with shiftEn high shifts nothing and restarts the count
    sendChain({mkFrame(8'd150, 6'd11, 1'b0), mkFrame(8'd20, 6'd22, 1'b0)});
    pulseStrobe(1'b1);
    expDlyNear = refCode(8'd20); expAttNear = 6'd22;
    expDlyFar = refCode(8'd150); expAttFar = 6'd11;
    checkAll("R7 strobe during shift");
    update(8'd64, 6'd44, 0, 8'd10, 6'd2, 0, 0, "R7 count restarted");

    // R5/R6: bad checksum on the far module only
    update(8'd99, 6'd3, 0, 8'd77, 6'd4, 1, 0, "R5 R6 far crc bad");

    // R5: strobe with no bits shifted is refused
    pulseStrobe(1'b0);
    expErrNear = 1'b1; expErrFar = 1'b1;
    checkAll("R5 R6 empty strobe");

    for (int n = 0; n < 40; n++) begin
      update(8'($urandom), 6'($urandom), ($urandom % 6) == 0,
             8'($urandom), 6'($urandom), ($urandom % 6) == 0,
             ($urandom % 8) == 0, "R5 R8 R9 R10 R11 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule